// File: doc/BRIEF.md
# Saturating Transmit Statistics Counters

This block counts four kinds of transmit events reported by a MAC: frames that met exactly one collision, frames that met several collisions, frames whose start was deferred, and frames whose deferral ran too long. The MAC signals each event with a pulse one clock wide on its own input bit. Each counter is 4 bits wide and stops at its largest value rather than rolling over.

Software reads all four counters at once as a 16-bit word by pulsing a read strobe. The word appears one cycle later, qualified by a valid flag. The same read clears all four counters. An interrupt request output goes high while any counter sits at its ceiling. It stays high until a read empties the counters.

The read side is a plain strobe-and-valid pair with no back-pressure. The reader must take `rd_data` in the cycle `rd_valid` is high. After that, `rd_data` keeps the last word returned until the next read.

Top module: `mac_stat_counters`

## Requirements
- R1: A synchronous reset sets all counters to zero and drives `irq` and `rd_valid` low. A read taken after reset returns 0x0000.
- R2: A pulse on `ev_pulse[i]` adds one to counter i only. Several bits pulsed in the same cycle each add one to their own counter.
- R3: The counters sit in the read word as follows: bits 3:0 single collisions (`ev_pulse[0]`), bits 7:4 multiple collisions (`ev_pulse[1]`), bits 11:8 deferred frames (`ev_pulse[2]`), bits 15:12 excessive deferrals (`ev_pulse[3]`).
- R4: A counter at 15 stays at 15 on further events and never returns to zero without a read or reset.
- R5: A read strobe in cycle t makes `rd_valid` high in cycle t+1 for one cycle, with `rd_data` holding the counters as they stood before edge t. All four counters are zero after that edge.
- R6: An event pulse in the same cycle as a read is left out of the returned word. That counter holds 1 after the clear, so the event is not lost.
- R7: `irq` is high whenever any counter equals 15, and it stays high through idle cycles and further events until a read.
- R8: After a read, `irq` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_pulse | input | 4 | One-cycle event pulses, one bit per counter |
| rd_en | input | 1 | Read strobe: capture and clear the counters |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a fresh word |
| rd_data | output | 16 | Packed counter word |
| irq | output | 1 | High while any counter is saturated |

## Verification
Each counter is driven alone, with a different number of events per counter, so that a swapped or misplaced field shows up in the word. All four are also pulsed together, which would expose any coupling between the increment paths. One counter is pushed well past 15 to separate saturation from wrap-around, and `irq` is sampled before, during and after the saturated span. A read is issued while events are pulsing, to tell a design that drops or double-counts a colliding event from one that defers it to the next window.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int DEF_CNT_W   = 4;
  localparam int DEF_NUM_CNT = 4;
endpackage

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ev,
  output logic [W-1:0] cnt,
  output logic         sat
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  assign sat = (cnt == MAX);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (clr)       cnt <= ev ? ONE : '0;   // colliding event opens the new window
    else if (ev && !sat) cnt <= cnt + ONE;
  end

  // R4: a full counter stays full until cleared
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    sat && !clr |=> sat);

  // R6: clear keeps only an event from the same cycle
  a_r6_clear_keeps_event: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == ($past(ev) ? ONE : '0)));

  // R2: a counter moves by at most one per event
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    !clr && !sat |=> (cnt == $past(cnt) + ($past(ev) ? ONE : '0)));
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic [W-1:0] word_in,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word_in;
    end
  end

  // R5: one valid pulse per strobe carrying the pre-clear word
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid && (rd_data == $past(word_in)));

  a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid && $stable(rd_data));
endmodule

// File: rtl/mac_stat_counters.sv
module mac_stat_counters #(
  parameter int CNT_W   = stat_pkg::DEF_CNT_W,
  parameter int NUM_CNT = stat_pkg::DEF_NUM_CNT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CNT-1:0]       ev_pulse,
  input  logic                     rd_en,
  output logic                     rd_valid,
  output logic [CNT_W*NUM_CNT-1:0] rd_data,
  output logic                     irq
);
  localparam int WORD_W = CNT_W * NUM_CNT;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            sat;
  logic [WORD_W-1:0]             word;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    stat_sat_counter #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (rd_en),
      .ev  (ev_pulse[i]),
      .cnt (cnt[i]),
      .sat (sat[i])
    );
    assign word[i*CNT_W +: CNT_W] = cnt[i];
  end

  assign irq = |sat;

  stat_read_port #(.W(WORD_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .word_in  (word),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R7: interrupt persists until a read
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (rst)
    irq && !rd_en |=> irq);

  // R8: a read always drops the interrupt
  a_r8_irq_drop: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !irq);

  // R1: reset leaves the outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !irq && !rd_valid);
endmodule

// File: tb/mac_stat_counters_test.sv
module mac_stat_counters_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ev_pulse = '0;
  logic        rd_en = 1'b0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int model [4];
  logic [15:0] exp_q [$];
  string tag_q [$];

  always #4 clk = ~clk;

  mac_stat_counters uut (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [15:0] model_word();
    logic [15:0] w;
    for (int i = 0; i < 4; i++) w[i*4 +: 4] = 4'(model[i]);
    return w;
  endfunction

  function automatic logic model_irq();
    logic any = 1'b0;
    for (int i = 0; i < 4; i++) if (model[i] == 15) any = 1'b1;
    return any;
  endfunction

  // driver: one cycle of stimulus, expected read word pushed to scoreboard
  task automatic cyc(input logic [3:0] e, input logic r, input string tag);
    @(negedge clk);
    ev_pulse = e;
    rd_en    = r;
    if (r) begin
      exp_q.push_back(model_word());
      tag_q.push_back(tag);
    end
    @(posedge clk);
    #2;
    ev_pulse = '0;
    rd_en    = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (r)                         model[i] = e[i] ? 1 : 0;
      else if (e[i] && model[i] < 15) model[i] = model[i] + 1;
    end
  endtask

  task automatic chk_irq(input string tag);
    tests++;
    if (irq !== model_irq()) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, model_irq());
    end
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each valid word against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5: unexpected rd_valid, rd_data actual %h expected none", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R1: reset state
    tests++;
    if (rd_valid !== 1'b0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1: rd_valid/irq actual %b%b expected 00", rd_valid, irq);
    end
    cyc(4'b0000, 1'b1, "R1 read after reset");
    drain();

    // R2: single counter
    repeat (3) cyc(4'b0001, 1'b0, "");
    cyc(4'b0000, 1'b1, "R2 three single collisions");
    drain();

    // R3: distinct counts expose field placement
    repeat (2) cyc(4'b0010, 1'b0, "");
    repeat (5) cyc(4'b0100, 1'b0, "");
    cyc(4'b1000, 1'b0, "");
    chk_irq("R7 no counter full");
    cyc(4'b0000, 1'b1, "R3 field layout");
    drain();

    // R2: all four at once
    repeat (7) cyc(4'b1111, 1'b0, "");
    cyc(4'b0000, 1'b1, "R2 simultaneous events");
    drain();

    // R4/R7: saturation and interrupt
    repeat (14) cyc(4'b0100, 1'b0, "");
    chk_irq("R7 at 14 irq low");
    cyc(4'b0100, 1'b0, "");
    chk_irq("R7 at 15 irq high");
    repeat (6) cyc(4'b0100, 1'b0, "");
    repeat (4) cyc(4'b0000, 1'b0, "");
    chk_irq("R7 irq held while idle");
    cyc(4'b0001, 1'b0, "");
    cyc(4'b0000, 1'b1, "R4 saturated at 15");
    chk_irq("R8 irq low after read");
    drain();

    // R6: event during read
    repeat (2) cyc(4'b0011, 1'b0, "");
    cyc(4'b1001, 1'b1, "R6 colliding event excluded");
    cyc(4'b0000, 1'b1, "R6 colliding event kept");
    drain();

    // R8: saturate two counters, read once
    repeat (16) cyc(4'b1010, 1'b0, "");
    chk_irq("R7 two counters full");
    cyc(4'b0000, 1'b1, "R4 two saturated");
    chk_irq("R8 irq cleared");
    drain();

    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5: missing words actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule